// File: doc/BRIEF.md
# Per-Block Write Protection Controller

This block keeps a protection state for every erase block of a boot-block style flash array and decides, request by request, whether a program or erase may proceed. The command decoder in front of it forwards every bus write (code byte and word address). Lock changes use a two-write sequence: a setup code followed by a confirm code, both aimed at the target block. A write-protect input, active low, supplies the hardware part of the protection scheme.

Each block is unlocked, locked, or locked-down. The locked-down marking can only be cleared by reset. While the write-protect input is low it pins the block in the protected state. While the input is high the block acts as an ordinary locked block. The address map is mixed. One 32-Kword region at the bottom (or, by parameter, at the top) of the space is split into eight 4-Kword parameter blocks. Every other 32-Kword region is a single main block. In identifier mode, reading a block's base address plus two returns its lock bits.

Program and erase requests get a permit or deny response one clock later. A refusal is recorded in a sticky error status byte, which also reports a malformed lock sequence.

Top module: `lockmgr`

## Requirements
- R1: While `rst` is high at a clock edge, every block becomes locked with its lock-down marking clear, `err_status` becomes 0 and no response is issued. The same holds after that edge.
- R2: A write with code 0x60, followed by a write with code 0x01, 0xD0 or 0x2F, respectively locks, unlocks or locks down the block addressed by the second write. The change is visible from the clock after the second write, and no other block changes.
- R3: Any other code in the confirm write is a sequence error. It sets `err_status` bits 4 and 5, changes no block, and ends the sequence.
- R4: `id_hit` is high exactly when `id_addr` sits at offset 2 from the base of its block. When it is high, `id_data` bit 0 shows whether the block is currently protected and bit 1 shows the lock-down marking. All other bits of `id_data` are 0, and all of `id_data` is 0 when `id_hit` is low.
- R5: With bottom boot, word addresses below 0x8000 form eight 4-Kword parameter blocks, numbered by address bits 14:12. Every higher 32-Kword region forms one main block.
- R6: A request (`req_valid` high) gets `rsp_valid` high on the next clock. `rsp_permit` is then high only if the addressed block was not protected at the request edge. A block is protected when it is locked, or when it is locked down and `wp_n` is low.
- R7: A refused program request sets `err_status` bits 1 and 4. A refused erase request sets bits 1 and 5. Bits stay set until a write with code 0x50 outside a lock sequence clears them. A flag set in the same cycle as that clear survives it.
- R8: While `wp_n` is low, a locked-down block ignores lock, unlock and lock-down confirms. It stays protected.
- R9: While `wp_n` is high, a locked-down block can be unlocked and relocked like a locked block. Its lock-down marking stays until reset, so driving `wp_n` low protects it again.
- R10: Writes outside a lock sequence with codes other than 0x60 and 0x50 change no block and no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wp_n | input | 1 | Hardware write protect, active low |
| cmd_valid | input | 1 | A bus write is presented |
| cmd_code | input | 8 | Low byte of the written data |
| cmd_addr | input | ADDR_W (21) | Word address of the write |
| req_valid | input | 1 | Program or erase request |
| req_erase | input | 1 | 1 for erase, 0 for program |
| req_addr | input | ADDR_W (21) | Word address of the request |
| id_addr | input | ADDR_W (21) | Identifier-mode read address |
| rsp_valid | output | 1 | Response to the previous cycle's request |
| rsp_permit | output | 1 | Request may proceed |
| err_status | output | 8 | Sticky error flags (bits 1, 4, 5) |
| id_hit | output | 1 | `id_addr` is a lock-status location |
| id_data | output | 16 | Lock bits of the addressed block |

## Verification
The embedded assertions check several properties on every cycle:
- reset leaves every block locked with no lock-down marking;
- a locked-down block under a low `wp_n` keeps its lock bit;
- the lock-down marking never falls without reset;
- every refusal or sequence error raises the matching status bits;
- a protected block never gets a permit.

Other properties depend on sequences of commands, so only the bench's scenarios can show them:
- the two-write lock protocol resolves to the correct block across parameter and main regions;
- the status offset decodes correctly;
- the same-cycle interplay between clear and new errors behaves as required;
- a locked-down block regains protection when `wp_n` is dropped again.

// File: rtl/lockmgr_pkg.sv
package lockmgr_pkg;

    localparam logic [7:0] CODE_SETUP  = 8'h60;
    localparam logic [7:0] CODE_LOCK   = 8'h01;
    localparam logic [7:0] CODE_UNLOCK = 8'hD0;
    localparam logic [7:0] CODE_LDOWN  = 8'h2F;
    localparam logic [7:0] CODE_CLRSTS = 8'h50;

    localparam int ERR_LOCKED = 1;
    localparam int ERR_PROG   = 4;
    localparam int ERR_ERASE  = 5;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_SET,
        OP_CLEAR,
        OP_DOWN
    } lock_op_e;

    typedef struct packed {
        logic ldown;
        logic locked;
    } blk_bits_t;

    function automatic int blocks_in_map(int aw, int mw, int pw);
        return (1 << (aw - mw)) - 1 + (1 << (mw - pw));
    endfunction

endpackage

// File: rtl/lm_addr_decode.sv
module lm_addr_decode #(
    parameter int ADDR_W   = 21,
    parameter int MAIN_W   = 15,
    parameter int PARAM_W  = 12,
    parameter bit BOOT_TOP = 1'b0,
    parameter int IDX_W    = 7
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              at_status
);
    localparam int REG_W  = ADDR_W - MAIN_W;
    localparam int SUB_W  = MAIN_W - PARAM_W;
    localparam int N_REG  = 1 << REG_W;
    localparam int N_PAR  = 1 << SUB_W;

    logic [REG_W-1:0] region;
    logic [SUB_W-1:0] sub;
    logic             in_param;
    logic [IDX_W-1:0] region_x, sub_x;

    assign region   = addr[ADDR_W-1:MAIN_W];
    assign sub      = addr[MAIN_W-1:PARAM_W];
    assign region_x = IDX_W'(region);
    assign sub_x    = IDX_W'(sub);

    generate
        if (BOOT_TOP) begin : g_top
            assign in_param = (region == REG_W'(N_REG - 1));
            assign idx = in_param ? (IDX_W'(N_REG - 1) + sub_x) : region_x;
        end else begin : g_bottom
            assign in_param = (region == '0);
            assign idx = in_param ? sub_x : (region_x + IDX_W'(N_PAR - 1));
        end
    endgenerate

    assign at_status = in_param ? (addr[PARAM_W-1:0] == PARAM_W'(2))
                                : (addr[MAIN_W-1:0]  == MAIN_W'(2));
endmodule

// File: rtl/lm_cmd_seq.sv
module lm_cmd_seq
    import lockmgr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_code,
    output lock_op_e   op,
    output logic       seq_err,
    output logic       clr_sts
);
    logic in_setup_q;

    always_comb begin
        op      = OP_NONE;
        seq_err = 1'b0;
        clr_sts = 1'b0;
        if (cmd_valid) begin
            if (in_setup_q) begin
                case (cmd_code)
                    CODE_LOCK:   op = OP_SET;
                    CODE_UNLOCK: op = OP_CLEAR;
                    CODE_LDOWN:  op = OP_DOWN;
                    default:     seq_err = 1'b1;
                endcase
            end else begin
                clr_sts = (cmd_code == CODE_CLRSTS);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            in_setup_q <= 1'b0;
        else if (cmd_valid)
            in_setup_q <= !in_setup_q && (cmd_code == CODE_SETUP);
    end
endmodule

// File: rtl/lm_lock_cell.sv
module lm_lock_cell
    import lockmgr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wp_n,
    input  logic      sel,
    input  lock_op_e  op,
    output blk_bits_t bits,
    output logic      protect
);
    blk_bits_t st_q;
    logic      frozen;

    assign frozen  = st_q.ldown && !wp_n;
    assign protect = st_q.locked || frozen;
    assign bits    = st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.locked <= 1'b1;
            st_q.ldown  <= 1'b0;
        end else if (sel && !frozen) begin
            case (op)
                OP_SET:   st_q.locked <= 1'b1;
                OP_CLEAR: st_q.locked <= 1'b0;
                OP_DOWN: begin
                    st_q.locked <= 1'b1;
                    st_q.ldown  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    AST_FROZEN_KEEPS_LOCK: assert property (@(posedge clk) disable iff (rst)
        (st_q.ldown && !wp_n) |=> $stable(st_q.locked)); // R8
    AST_LDOWN_STICKY: assert property (@(posedge clk) disable iff (rst)
        st_q.ldown |=> st_q.ldown); // R9
endmodule

// File: rtl/lm_err_status.sv
module lm_err_status
    import lockmgr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       deny_prog,
    input  logic       deny_erase,
    input  logic       seq_err,
    input  logic       clr,
    output logic [7:0] status
);
    logic [7:0] sets;

    always_comb begin
        sets = '0;
        if (deny_prog || deny_erase) sets[ERR_LOCKED] = 1'b1;
        if (deny_prog  || seq_err)   sets[ERR_PROG]   = 1'b1;
        if (deny_erase || seq_err)   sets[ERR_ERASE]  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            status <= '0;
        else
            status <= (clr ? 8'h00 : status) | sets;
    end

    AST_SEQ_ERR_FLAGS: assert property (@(posedge clk) disable iff (rst)
        seq_err |=> (status[ERR_PROG] && status[ERR_ERASE])); // R3
    AST_DENY_PROG_FLAGS: assert property (@(posedge clk) disable iff (rst)
        deny_prog |=> (status[ERR_LOCKED] && status[ERR_PROG])); // R7
endmodule

// File: rtl/lockmgr.sv
module lockmgr
    import lockmgr_pkg::*;
#(
    parameter int ADDR_W   = 21,
    parameter int MAIN_W   = 15,
    parameter int PARAM_W  = 12,
    parameter bit BOOT_TOP = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_code,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              req_valid,
    input  logic              req_erase,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] id_addr,
    output logic              rsp_valid,
    output logic              rsp_permit,
    output logic [7:0]        err_status,
    output logic              id_hit,
    output logic [15:0]       id_data
);
    localparam int N_BLK = blocks_in_map(ADDR_W, MAIN_W, PARAM_W);
    localparam int IDX_W = $clog2(N_BLK);

    logic [IDX_W-1:0] cmd_idx, req_idx, id_idx;
    logic             cmd_at_sts, req_at_sts;
    lock_op_e         op;
    logic             seq_err, clr_sts;
    logic [N_BLK-1:0] protect, locked_v, ldown_v;
    logic             req_prot, deny_prog, deny_erase;

    lm_addr_decode #(.ADDR_W(ADDR_W), .MAIN_W(MAIN_W), .PARAM_W(PARAM_W),
                     .BOOT_TOP(BOOT_TOP), .IDX_W(IDX_W))
        u_dec_cmd (.addr(cmd_addr), .idx(cmd_idx), .at_status(cmd_at_sts));
    lm_addr_decode #(.ADDR_W(ADDR_W), .MAIN_W(MAIN_W), .PARAM_W(PARAM_W),
                     .BOOT_TOP(BOOT_TOP), .IDX_W(IDX_W))
        u_dec_req (.addr(req_addr), .idx(req_idx), .at_status(req_at_sts));
    lm_addr_decode #(.ADDR_W(ADDR_W), .MAIN_W(MAIN_W), .PARAM_W(PARAM_W),
                     .BOOT_TOP(BOOT_TOP), .IDX_W(IDX_W))
        u_dec_id (.addr(id_addr), .idx(id_idx), .at_status(id_hit));

    lm_cmd_seq u_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .op(op), .seq_err(seq_err), .clr_sts(clr_sts)
    );

    generate
        for (genvar b = 0; b < N_BLK; b++) begin : g_blk
            blk_bits_t bb;
            lm_lock_cell u_cell (
                .clk(clk), .rst(rst), .wp_n(wp_n),
                .sel(cmd_idx == IDX_W'(b)), .op(op),
                .bits(bb), .protect(protect[b])
            );
            assign locked_v[b] = bb.locked;
            assign ldown_v[b]  = bb.ldown;
        end
    endgenerate

    assign req_prot   = protect[req_idx];
    assign deny_prog  = req_valid && req_prot && !req_erase;
    assign deny_erase = req_valid && req_prot && req_erase;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_permit <= 1'b0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_permit <= req_valid && !req_prot;
        end
    end

    lm_err_status u_sts (
        .clk(clk), .rst(rst), .deny_prog(deny_prog), .deny_erase(deny_erase),
        .seq_err(seq_err), .clr(clr_sts), .status(err_status)
    );

    always_comb begin
        id_data = '0;
        if (id_hit) begin
            id_data[0] = protect[id_idx];
            id_data[1] = ldown_v[id_idx];
        end
    end

    AST_RST_ALL_LOCKED: assert property (@(posedge clk)
        rst |=> ((&locked_v) && !(|ldown_v) && !rsp_valid)); // R1
    AST_NO_PERMIT_PROTECTED: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_prot) |=> (rsp_valid && !rsp_permit)); // R6
    AST_DENY_ERASE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        deny_erase |=> (err_status[1] && err_status[5])); // R7
endmodule

// File: tb/sim_lockmgr.sv
module sim_lockmgr;
    localparam int AW = 21;
    localparam int NB = 71;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wp_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [7:0]    cmd_code = 8'h00;
    logic [AW-1:0] cmd_addr = '0;
    logic          req_valid = 1'b0;
    logic          req_erase = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [AW-1:0] id_addr = '0;
    logic          rsp_valid, rsp_permit, id_hit;
    logic [7:0]    err_status;
    logic [15:0]   id_data;

    always #5 clk = ~clk;

    lockmgr u0 (
        .clk(clk), .rst(rst), .wp_n(wp_n), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .cmd_addr(cmd_addr), .req_valid(req_valid),
        .req_erase(req_erase), .req_addr(req_addr), .id_addr(id_addr),
        .rsp_valid(rsp_valid), .rsp_permit(rsp_permit),
        .err_status(err_status), .id_hit(id_hit), .id_data(id_data)
    );

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    bit m_lk[NB];
    bit m_ld[NB];
    bit m_setup;
    bit m_rv, m_rp;
    int m_sts;

    function automatic int blk_of(int a);
        if (a < 32768) return a / 4096;
        return a / 32768 + 7;
    endfunction

    function automatic bit at_sts(int a);
        if (a < 32768) return (a % 4096) == 2;
        return (a % 32768) == 2;
    endfunction

    function automatic bit prot(int b);
        return m_lk[b] || (m_ld[b] && !wp_n);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_update();
        if (rst) begin
            for (int b = 0; b < NB; b++) begin m_lk[b] = 1; m_ld[b] = 0; end
            m_setup = 0; m_rv = 0; m_rp = 0; m_sts = 0;
        end else begin
            int sets = 0;
            bit clr = 0;
            int cb = blk_of(int'(cmd_addr));
            int rb = blk_of(int'(req_addr));
            m_rv = req_valid;
            m_rp = req_valid && !prot(rb);
            if (req_valid && prot(rb)) sets |= req_erase ? 8'h22 : 8'h12;
            if (cmd_valid) begin
                if (m_setup) begin
                    bit frozen = m_ld[cb] && !wp_n;
                    m_setup = 0;
                    if (cmd_code == 8'h01)      begin if (!frozen) m_lk[cb] = 1; end
                    else if (cmd_code == 8'hD0) begin if (!frozen) m_lk[cb] = 0; end
                    else if (cmd_code == 8'h2F) begin if (!frozen) begin m_lk[cb] = 1; m_ld[cb] = 1; end end
                    else sets |= 8'h30;
                end else begin
                    m_setup = (cmd_code == 8'h60);
                    clr = (cmd_code == 8'h50);
                end
            end
            m_sts = (clr ? 0 : m_sts) | sets;
        end
    endtask

    task automatic compare_all();
        int ib = blk_of(int'(id_addr));
        bit h = at_sts(int'(id_addr));
        int exp_id = h ? ((int'(m_ld[ib]) << 1) | int'(prot(ib))) : 0;
        chk("R6 rsp_valid", int'(rsp_valid), int'(m_rv));
        chk("R6 rsp_permit", int'(rsp_permit), int'(m_rp));
        chk("R7 err_status", int'(err_status), m_sts);
        chk("R4 id_hit", int'(id_hit), int'(h));
        chk("R4 id_data", int'(id_data), exp_id);
    endtask

    task automatic tick();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_all();
        cmd_valid = 0;
        req_valid = 0;
    endtask

    task automatic wr(input logic [7:0] code, input int a);
        cmd_valid = 1; cmd_code = code; cmd_addr = AW'(a);
        tick();
    endtask

    task automatic lockcmd(input logic [7:0] code, input int a);
        wr(8'h60, a);
        wr(code, a);
    endtask

    task automatic req(input bit erase, input int a);
        req_valid = 1; req_erase = erase; req_addr = AW'(a);
        tick();
    endtask

    task automatic idrd(input string tag, input int a, input int exp);
        id_addr = AW'(a);
        #1;
        chk(tag, int'(id_data), exp);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) tick();
        rst = 0;
        tick();
        // R1 reset state
        chk("R1 status", int'(err_status), 0);
        chk("R1 no rsp", int'(rsp_valid), 0);
        idrd("R1 param blk0 locked", 2, 1);
        idrd("R1 main blk locked", 40 * 32768 + 2, 1);

        // R2 + R5: unlock parameter block 3
        lockcmd(8'hD0, 3 * 4096 + 5);
        idrd("R2 blk3 unlocked", 3 * 4096 + 2, 0);
        idrd("R2 blk2 untouched", 2 * 4096 + 2, 1);
        idrd("R5 blk4 untouched", 4 * 4096 + 2, 1);

        // R6/R7
        req(0, 3 * 4096 + 77);
        chk("R6 permit unlocked", int'(rsp_permit), 1);
        req(0, 4 * 4096 + 1);
        chk("R6 deny locked", int'(rsp_permit), 0);
        chk("R7 prog deny flags", int'(err_status), 8'h12);
        wr(8'h50, 0);
        chk("R7 clear", int'(err_status), 0);
        req(1, 9 * 32768);
        chk("R7 erase deny flags", int'(err_status), 8'h22);
        cmd_valid = 1; cmd_code = 8'h50; req_valid = 1; req_erase = 0; req_addr = '0;
        tick();
        chk("R7 set beats clear", int'(err_status), 8'h12);
        wr(8'h50, 0);

        // R3 sequence error
        wr(8'h60, 3 * 4096);
        wr(8'hFF, 3 * 4096);
        chk("R3 seq error flags", int'(err_status), 8'h30);
        idrd("R3 no state change", 3 * 4096 + 2, 0);
        wr(8'h50, 0);

        // R5 + R4 main block geometry
        lockcmd(8'hD0, 5 * 32768 + 100);
        idrd("R5 main region5 unlocked", 5 * 32768 + 2, 0);
        id_addr = AW'(5 * 32768 + 4096 + 2);
        #1;
        chk("R4 off-base no hit", int'(id_hit), 0);
        idrd("R5 region4 locked", 4 * 32768 + 2, 1);

        // R8 lock-down with wp_n low
        lockcmd(8'h2F, 5 * 32768);
        idrd("R8 locked-down bits", 5 * 32768 + 2, 3);
        lockcmd(8'hD0, 5 * 32768);
        idrd("R8 unlock ignored", 5 * 32768 + 2, 3);
        req(0, 5 * 32768 + 9);
        chk("R8 deny", int'(rsp_permit), 0);
        wr(8'h50, 0);

        // R9 wp_n high
        wp_n = 1;
        lockcmd(8'hD0, 5 * 32768);
        idrd("R9 unlock allowed", 5 * 32768 + 2, 2);
        req(1, 5 * 32768 + 9);
        chk("R9 permit", int'(rsp_permit), 1);
        wp_n = 0;
        idrd("R9 reprotect", 5 * 32768 + 2, 3);
        req(1, 5 * 32768 + 9);
        chk("R9 deny again", int'(rsp_permit), 0);
        wr(8'h50, 0);

        // R10 stray codes
        wr(8'h01, 3 * 4096);
        wr(8'h2F, 3 * 4096);
        wr(8'hD0, 4 * 4096);
        idrd("R10 blk3 unchanged", 3 * 4096 + 2, 0);
        idrd("R10 blk4 unchanged", 4 * 4096 + 2, 1);
        chk("R10 status clean", int'(err_status), 0);

        // mixed traffic against the model
        for (int i = 0; i < 400; i++) begin
            int pick = $urandom_range(0, 5);
            logic [7:0] codes[6] = '{8'h60, 8'h01, 8'hD0, 8'h2F, 8'h50, 8'hFF};
            int a = (i % 3 == 0) ? $urandom_range(0, 32767) : $urandom_range(0, 2097151);
            if ($urandom_range(0, 9) == 0) wp_n = ~wp_n;
            cmd_valid = $urandom_range(0, 1);
            cmd_code = codes[pick];
            cmd_addr = AW'(a);
            req_valid = $urandom_range(0, 1);
            req_erase = $urandom_range(0, 1);
            req_addr = AW'((i % 2) ? a : $urandom_range(0, 2097151));
            id_addr = AW'(blk_of(a) < 8 ? (a & ~4095) + 2 : (a & ~32767) + 2);
            tick();
        end

        // R1/R10 reset restores everything
        rst = 1;
        tick();
        rst = 0;
        tick();
        idrd("R1 reset relocks blk3", 3 * 4096 + 2, 1);
        idrd("R1 reset clears lockdown", 5 * 32768 + 2, 1);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule